// File: doc/BRIEF.md
# Debug Port Register Bank Router

This block sits on the target side of a debug link, behind the serial protocol engine. Each transaction it receives has already been decoded into a port-kind flag (debug-port register or access-port register), a read/write flag, two word-address bits and a 32-bit write word. Accesses to debug-port registers are served locally. Among these registers is a select register, which holds an access-port number, an access-port bank and a debug-port bank.

Accesses to access-port registers are forwarded over an internal valid/ready request bus. Each request carries the port number from the select register and a full byte address built from the bank and the two address bits. The reply comes back on a single-cycle response strobe. While a request is outstanding, the router raises busy, which the protocol engine turns into a WAIT acknowledge. Access-port reads are posted: each returns the result of the previous one, and the newest result stays available in a read-buffer register.

Top module: `dbg_bank_router`

## Requirements
- R1: After reset the select register and the read buffer are zero, `txn_busy`, `txn_done` and `bus_req_valid` are low.
- R2: A debug-port write with address bits 2 loads the whole select register. A debug-port read at 2 returns it. Debug-port writes at 0, 1 and 3 leave it unchanged.
- R3: A debug-port read at address 0 returns the `ID_CODE` parameter.
- R4: A debug-port read at address 1 returns `ctrl_stat` when select bits [3:0] are zero, and zero for any other debug-port bank value.
- R5: An access-port access to a present port issues one request. Its port is select bits [31:24]. Its byte address is {select bits [7:4], address bits, 2'b00}. Its write flag is the inverse of the read flag, and its data is the write word.
- R6: An access-port read returns the read-buffer value held before it and then loads the buffer with the response data. A debug-port read at address 3 returns the buffer and issues no request.
- R7: An access-port access to a port number of `NUM_AP` or above issues no request and completes one cycle after acceptance. A write returns zero. A read returns the old buffer value and clears the buffer.
- R8: A request holds its valid, port, address and data until accepted. `txn_busy` is high from acceptance of an access-port access until its response. Transactions offered while busy are ignored.
- R9: An access-port write completes with read data zero and leaves the read buffer unchanged.
- R10: A debug-port access completes with `txn_done` high in the cycle after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| txn_valid | input | 1 | Decoded transaction offered (taken when not busy) |
| txn_ap | input | 1 | 1 = access-port register, 0 = debug-port register |
| txn_rd | input | 1 | 1 = read, 0 = write |
| txn_addr | input | 2 | Word address bits A[3:2] |
| txn_wdata | input | 32 | Write word |
| ctrl_stat | input | 32 | Control/status value returned in debug-port bank 0 at address 1 |
| txn_busy | output | 1 | Access-port request outstanding (WAIT) |
| txn_done | output | 1 | One-cycle completion strobe |
| txn_rdata | output | 32 | Read result, valid with `txn_done` |
| bus_req_valid | output | 1 | Request valid |
| bus_req_ready | input | 1 | Request accepted |
| bus_req_port | output | 8 | Target access-port number |
| bus_req_addr | output | 8 | Register byte address |
| bus_req_write | output | 1 | 1 = write request |
| bus_req_wdata | output | 32 | Write data |
| bus_rsp_valid | input | 1 | Response strobe |
| bus_rsp_rdata | input | 32 | Response read data |

## Verification
The bench builds the router with `NUM_AP` = 2. Ports 0 and 1 reach a small word memory model, and port 2 is the first absent number, so the no-request completion path is reachable. The bench picks the bank so that the same address bits land on different byte addresses. It stalls the request ready for several cycles, which exposes request stability and the ignoring of transactions while busy. Tracking the read buffer across writes, absent-port reads and posted reads checks its one-behind ordering.

// File: rtl/dbg_bank_router.sv
module dbg_bank_router #(
  parameter int          NUM_AP  = 2,
  parameter logic [31:0] ID_CODE = 32'h1D0B_A5E1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        txn_valid,
  input  logic        txn_ap,
  input  logic        txn_rd,
  input  logic [1:0]  txn_addr,
  input  logic [31:0] txn_wdata,
  input  logic [31:0] ctrl_stat,
  output logic        txn_busy,
  output logic        txn_done,
  output logic [31:0] txn_rdata,
  output logic        bus_req_valid,
  input  logic        bus_req_ready,
  output logic [7:0]  bus_req_port,
  output logic [7:0]  bus_req_addr,
  output logic        bus_req_write,
  output logic [31:0] bus_req_wdata,
  input  logic        bus_rsp_valid,
  input  logic [31:0] bus_rsp_rdata
);
  localparam logic [1:0] A_ID = 2'd0, A_STAT = 2'd1, A_SEL = 2'd2, A_RBUF = 2'd3;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} st_t;

  st_t         state;
  logic [31:0] sel_q, rbuf_q, rdata_q, wdata_q;
  logic [7:0]  port_q, addr_q;
  logic        wr_q, done_q;

  wire [7:0] ap_num     = sel_q[31:24];
  wire [3:0] ap_bank    = sel_q[7:4];
  wire [3:0] dp_bank    = sel_q[3:0];
  wire       ap_present = int'(ap_num) < NUM_AP;

  logic [31:0] dp_rd;
  always_comb begin
    case (txn_addr)
      A_ID:    dp_rd = ID_CODE;
      A_STAT:  dp_rd = (dp_bank == 4'd0) ? ctrl_stat : 32'd0;
      A_SEL:   dp_rd = sel_q;
      A_RBUF:  dp_rd = rbuf_q;
      default: dp_rd = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sel_q   <= '0;
      rbuf_q  <= '0;
      rdata_q <= '0;
      wdata_q <= '0;
      port_q  <= '0;
      addr_q  <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state)
        S_IDLE: if (txn_valid) begin
          if (!txn_ap) begin
            done_q  <= 1'b1;
            rdata_q <= txn_rd ? dp_rd : 32'd0;
            if (!txn_rd && txn_addr == A_SEL) sel_q <= txn_wdata;
          end else if (!ap_present) begin
            done_q  <= 1'b1;
            rdata_q <= txn_rd ? rbuf_q : 32'd0;
            if (txn_rd) rbuf_q <= '0;
          end else begin
            state   <= S_REQ;
            port_q  <= ap_num;
            addr_q  <= {ap_bank, txn_addr, 2'b00};
            wr_q    <= !txn_rd;
            wdata_q <= txn_wdata;
          end
        end
        S_REQ: if (bus_req_ready) state <= S_RSP;
        S_RSP: if (bus_rsp_valid) begin
          state  <= S_IDLE;
          done_q <= 1'b1;
          if (wr_q) rdata_q <= '0;
          else begin
            rdata_q <= rbuf_q;
            rbuf_q  <= bus_rsp_rdata;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign txn_busy      = state != S_IDLE;
  assign txn_done      = done_q;
  assign txn_rdata     = rdata_q;
  assign bus_req_valid = state == S_REQ;
  assign bus_req_port  = port_q;
  assign bus_req_addr  = addr_q;
  assign bus_req_write = wr_q;
  assign bus_req_wdata = wdata_q;

  a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid && !bus_req_ready |=> bus_req_valid && $stable(bus_req_addr)
      && $stable(bus_req_port) && $stable(bus_req_wdata) && $stable(bus_req_write));
  a_r8_busy_with_req: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> txn_busy);
  a_r7_req_port_present: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_valid |-> int'(bus_req_port) < NUM_AP);
  a_r5_req_from_ap_txn: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req_valid) |-> $past(txn_valid && txn_ap));
endmodule

// File: tb/dbg_bank_router_tb.sv
module dbg_bank_router_tb;
  localparam logic [31:0] ID = 32'h1D0B_A5E1;

  logic clk = 0, rst_n = 0;
  logic txn_valid = 0, txn_ap = 0, txn_rd = 0;
  logic [1:0] txn_addr = 0;
  logic [31:0] txn_wdata = 0, ctrl_stat = 32'h1234_5678;
  logic txn_busy, txn_done, bus_req_valid, bus_req_write;
  logic [31:0] txn_rdata, bus_req_wdata;
  logic [7:0] bus_req_port, bus_req_addr;
  logic bus_req_ready = 1, bus_rsp_valid = 0;
  logic [31:0] bus_rsp_rdata = 0;

  int checks = 0, fails = 0, hs_count = 0, stall_left = 0;
  logic [31:0] mem [2][64];
  logic [7:0] last_port, last_addr;
  logic last_wr;
  logic [31:0] last_wdata, pend_data, exp_rbuf;
  bit pend = 0, finished = 0;

  always #4 clk = ~clk;

  dbg_bank_router #(.NUM_AP(2), .ID_CODE(ID)) u_dut (
    .clk, .rst_n, .txn_valid, .txn_ap, .txn_rd, .txn_addr, .txn_wdata, .ctrl_stat,
    .txn_busy, .txn_done, .txn_rdata, .bus_req_valid, .bus_req_ready, .bus_req_port,
    .bus_req_addr, .bus_req_write, .bus_req_wdata, .bus_rsp_valid, .bus_rsp_rdata);

  always @(negedge clk) begin
    bus_rsp_valid = 0;
    if (stall_left > 0) begin bus_req_ready = 0; stall_left--; end
    else bus_req_ready = 1;
    if (pend) begin
      bus_rsp_valid = 1; bus_rsp_rdata = pend_data; pend = 0;
    end else if (bus_req_valid && bus_req_ready) begin
      hs_count++;
      last_port = bus_req_port; last_addr = bus_req_addr;
      last_wr = bus_req_write; last_wdata = bus_req_wdata;
      if (bus_req_write) begin
        mem[bus_req_port[0]][bus_req_addr[7:2]] = bus_req_wdata; pend_data = 0;
      end else pend_data = mem[bus_req_port[0]][bus_req_addr[7:2]];
      pend = 1;
    end
  end

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic txn(bit ap, bit rd, logic [1:0] a, logic [31:0] wd,
                     output logic [31:0] rv, output int lat);
    @(negedge clk);
    txn_valid = 1; txn_ap = ap; txn_rd = rd; txn_addr = a; txn_wdata = wd;
    @(posedge clk); #1 txn_valid = 0;
    lat = 1;
    while (!txn_done && lat < 100) begin @(posedge clk); #1 lat++; end
    rv = txn_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v; int l;
    chk(!txn_busy && !txn_done && !bus_req_valid, "R1 idle outputs",
        {txn_busy, txn_done, bus_req_valid}, 0);
    txn(0, 1, 2, 0, v, l); chk(v == 0, "R1 select reset", v, 0);
    txn(0, 1, 3, 0, v, l); chk(v == 0, "R1 rbuf reset", v, 0);
  endtask

  task automatic t_dp_regs;
    logic [31:0] v; int l;
    txn(0, 1, 0, 0, v, l); chk(v == ID, "R3 id read", v, ID);
    chk(l == 1, "R10 dp latency", l, 1);
    txn(0, 0, 2, 32'hA500_00F3, v, l);
    chk(l == 1, "R10 dp write latency", l, 1);
    txn(0, 1, 2, 0, v, l); chk(v == 32'hA500_00F3, "R2 select readback", v, 32'hA500_00F3);
    txn(0, 0, 0, 32'h1111_1111, v, l);
    txn(0, 0, 1, 32'h2222_2222, v, l);
    txn(0, 0, 3, 32'h3333_3333, v, l);
    txn(0, 1, 2, 0, v, l); chk(v == 32'hA500_00F3, "R2 other writes ignored", v, 32'hA500_00F3);
    txn(0, 1, 1, 0, v, l); chk(v == 0, "R4 dp bank 3 reads zero", v, 0);
    txn(0, 0, 2, 32'h0000_0000, v, l);
    txn(0, 1, 1, 0, v, l); chk(v == ctrl_stat, "R4 dp bank 0 ctrl_stat", v, ctrl_stat);
  endtask

  task automatic t_ap_write_bank;
    logic [31:0] v; int l;
    txn(0, 0, 2, 32'h0000_0010, v, l);
    txn(1, 0, 1, 32'hF000_0001, v, l);
    chk(last_port == 0 && last_addr == 8'h14 && last_wr, "R5 bank1 A1 -> 0x14",
        {last_port, last_addr, 15'd0, last_wr}, {8'h00, 8'h14, 16'h0001});
    chk(last_wdata == 32'hF000_0001, "R5 write data", last_wdata, 32'hF000_0001);
    chk(v == 0, "R9 write returns zero", v, 0);
    txn(1, 0, 0, 32'hAAAA_0010, v, l); chk(last_addr == 8'h10, "R5 A0 -> 0x10", last_addr, 8'h10);
    txn(1, 0, 3, 32'hAAAA_001C, v, l); chk(last_addr == 8'h1C, "R5 A3 -> 0x1C", last_addr, 8'h1C);
  endtask

  task automatic t_ap_read_posted;
    logic [31:0] v; int l; int h;
    txn(0, 0, 2, 32'h0100_0020, v, l);
    txn(1, 0, 1, 32'hCAFE_0024, v, l);
    chk(last_port == 1 && last_addr == 8'h24, "R5 port1 bank2",
        {last_port, last_addr}, 16'h0124);
    txn(0, 1, 3, 0, v, l); chk(v == exp_rbuf, "R9 write leaves rbuf", v, exp_rbuf);
    txn(1, 1, 1, 0, v, l); chk(v == exp_rbuf, "R6 first read returns old rbuf", v, exp_rbuf);
    exp_rbuf = 32'hCAFE_0024;
    txn(1, 1, 1, 0, v, l); chk(v == exp_rbuf, "R6 second read returns prior", v, exp_rbuf);
    h = hs_count;
    txn(0, 1, 3, 0, v, l); chk(v == exp_rbuf, "R6 rbuf read", v, exp_rbuf);
    chk(hs_count == h, "R6 rbuf read no request", hs_count, h);
  endtask

  task automatic t_absent;
    logic [31:0] v; int l; int h;
    txn(0, 0, 2, 32'h0200_0000, v, l);
    h = hs_count;
    txn(1, 0, 1, 32'hDEAD_BEEF, v, l);
    chk(l == 1 && v == 0, "R7 absent write", {v[15:0], 16'(l)}, 32'h0000_0001);
    txn(1, 1, 1, 0, v, l); chk(v == exp_rbuf, "R7 absent read old rbuf", v, exp_rbuf);
    chk(l == 1, "R7 absent read latency", l, 1);
    chk(hs_count == h, "R7 no request", hs_count, h);
    exp_rbuf = 0;
    txn(0, 1, 3, 0, v, l); chk(v == 0, "R7 rbuf cleared", v, 0);
  endtask

  task automatic t_stall;
    logic [31:0] v; int l; bit busy_ok = 1;
    txn(0, 0, 2, 32'h0000_0010, v, l);
    stall_left = 5;
    @(negedge clk);
    txn_valid = 1; txn_ap = 1; txn_rd = 0; txn_addr = 2; txn_wdata = 32'h5A5A_0018;
    @(posedge clk); #1;
    txn_ap = 0; txn_addr = 2; txn_wdata = 32'hFFFF_FFFF;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); if (!txn_busy || !bus_req_valid) busy_ok = 0;
    end
    txn_valid = 0;
    chk(busy_ok, "R8 busy while stalled", busy_ok, 1);
    l = 0;
    while (!txn_done && l < 100) begin @(posedge clk); #1 l++; end
    chk(l >= 4 && last_addr == 8'h18 && last_wdata == 32'h5A5A_0018, "R8 stalled request",
        {last_addr, 24'(l)}, {8'h18, 24'd4});
    txn(0, 1, 2, 0, v, l); chk(v == 32'h0000_0010, "R8 select write while busy ignored",
        v, 32'h0000_0010);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < 2; p++) for (int w = 0; w < 64; w++) mem[p][w] = 0;
    exp_rbuf = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    t_reset;
    t_dp_regs;
    t_ap_write_bank;
    t_ap_read_posted;
    t_absent;
    t_stall;
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule